// File: doc/BRIEF.md
# SPI Master Slave-Select Sequencer

This block drives one SPI link as master and controls when a frame may go out. A transfer request carries a data word, a bit count and its timing settings. The request is taken only while an external ready line is high. After a request is taken, the block lowers the slave-select line and waits a lead time. It then clocks the frame out in mode 0 and waits a lag time before it raises slave-select. It then holds slave-select high for a programmable gap before it takes another request. The receive word is assembled from the input data line during the same burst.

The serial clock period is the system clock period times 4, 8, 16, up to 512, chosen by a 3-bit divider select. Lead, lag and gap are counted in whole serial clock periods, so all guard times scale with the selected rate. A separate small checker watches a slave-select input and a serial clock input. It pulses a flag when a clock rising edge arrives in the same system clock sample as the select falling edge, which is too early.

Top module: `spi_ss_seq`

## Requirements
- R1: A request is accepted only on a clock edge where the block is idle and both `req_valid` and `spi_rdy` are high, and `req_ready` shows exactly that condition. While `spi_rdy` stays low, a pending request waits indefinitely with `ss_n` high and `sclk` low.
- R2: `ss_n` falls exactly 2 system clocks after the accepting edge.
- R3: The first rising `sclk` edge comes 3·P + P/2 system clocks after `ss_n` falls, where P is the serial clock period in system clocks.
- R4: `ss_n` rises exactly 2·P system clocks after the last falling `sclk` edge of the frame.
- R5: Between frames, `ss_n` stays high for at least (1 + `wait_cnt`)·P clocks. When the next request is already pending, `ss_n` stays high for exactly (1 + `wait_cnt`)·P + 3 clocks, using the previous frame's settings.
- R6: P = 4 << `div_sel`, so rising edges inside a frame are P clocks apart. `sclk` idles low and is low whenever `ss_n` is high.
- R7: A frame carries L = `req_len_m1` + 1 bits (1 to 32). These are the low L bits of `req_data`, sent most significant bit first on `mosi`. `mosi` changes only on falling `sclk` edges.
- R8: `miso` is sampled on each rising `sclk` edge. From the end of the frame, `rx_data` holds the L received bits right-aligned, with the first bit received in bit L-1 and the bits above it zero.
- R9: `done` is a one-cycle pulse in the same cycle that `ss_n` rises.
- R10: `slv_early` pulses high for one cycle after a sample in which `slv_ss_n` has just fallen and `slv_sclk` has just risen together. It stays low when the clock rises one or more system clocks after the select falls.
- R11: After reset, `ss_n` is 1, `sclk` is 0, `done` is 0, `slv_early` is 0 and `rx_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request pending |
| req_data | input | 32 | Transmit word; the low L bits are sent |
| req_len_m1 | input | 5 | Frame length minus one |
| div_sel | input | 3 | Serial clock divider select, P = 4 << div_sel |
| wait_cnt | input | 8 | Extra idle serial clock periods between frames |
| spi_rdy | input | 1 | External ready; gates request acceptance |
| req_ready | output | 1 | Request is taken on this edge if valid |
| ss_n | output | 1 | Slave select, active low |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| rx_data | output | 32 | Received word, right-aligned |
| done | output | 1 | Frame complete pulse |
| slv_ss_n | input | 1 | Slave-mode select input to check |
| slv_sclk | input | 1 | Slave-mode clock input to check |
| slv_early | output | 1 | Slave clock edge arrived too soon after select |

## Verification
The assertions assume the following about the inputs:
- All inputs are synchronous to `clk`.
- `spi_rdy` keeps the value it had at the accepting edge long enough for the ready-to-select property to look back three cycles.
- Settings only need to be valid at the accepting edge, because they are latched there.

The stimulus changes every input only on the falling clock edge and raises ready together with or before the request. A bench slave model updates `miso` only on observed falling `sclk` edges, which keeps the sampled data well defined at each rising edge.

// File: rtl/spi_ss_seq_pkg.sv
package spi_ss_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DLY,
        ST_LEAD,
        ST_SHIFT,
        ST_LAG,
        ST_GAP
    } seq_state_e;

endpackage

// File: rtl/spi_ss_seq_timer.sv
// Phase counter within one serial clock period plus a count of whole periods.
module spi_ss_seq_timer #(
    parameter int DIV_SEL_W = 3,
    parameter int PER_W     = 9,
    localparam int PH_W     = (1 << DIV_SEL_W) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 clr,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 mid,
    output logic                 last,
    output logic [PER_W-1:0]     per
);

    typedef struct packed {
        logic [PH_W-1:0]  ph;
        logic [PER_W-1:0] per;
    } tmr_t;

    tmr_t             d, q;
    logic [PH_W-1:0]  per_m1;
    logic [PH_W-1:0]  half_m1;

    always_comb begin
        per_m1  = (PH_W'(4) << div_sel) - PH_W'(1);
        half_m1 = (PH_W'(2) << div_sel) - PH_W'(1);
        mid     = (q.ph == half_m1);
        last    = (q.ph == per_m1);
        per     = q.per;
        d       = q;
        if (clr) begin
            d.ph  = '0;
            d.per = '0;
        end else if (run) begin
            if (last) begin
                d.ph  = '0;
                d.per = q.per + PER_W'(1);
            end else begin
                d.ph = q.ph + PH_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_ss_seq_shift.sv
// Transmit and receive shift registers, MSB first.
module spi_ss_seq_shift #(
    parameter int MAX_BITS = 32,
    parameter int LEN_W    = $clog2(MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_BITS-1:0] data,
    input  logic [LEN_W-1:0]    len_m1,
    input  logic                shift_out,
    input  logic                sample_in,
    input  logic                miso,
    output logic                mosi,
    output logic [MAX_BITS-1:0] rx_data
);

    typedef struct packed {
        logic [MAX_BITS-1:0] tx;
        logic [MAX_BITS-1:0] rx;
    } sh_t;

    sh_t              d, q;
    logic [LEN_W-1:0] align;

    always_comb begin
        align = LEN_W'(MAX_BITS - 1) - len_m1;
        d     = q;
        if (load) begin
            d.tx = data << align;
            d.rx = '0;
        end else begin
            if (shift_out) d.tx = {q.tx[MAX_BITS-2:0], 1'b0};
            if (sample_in) d.rx = {q.rx[MAX_BITS-2:0], miso};
        end
        mosi    = q.tx[MAX_BITS-1];
        rx_data = q.rx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/spi_ss_seq_slvchk.sv
// Flags a slave clock rise that shares its sample with the select fall.
module spi_ss_seq_slvchk (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_in_n,
    input  logic sclk_in,
    output logic early
);

    typedef struct packed {
        logic ss_n;
        logic sclk;
        logic err;
    } chk_t;

    chk_t d, q;

    always_comb begin
        d.ss_n = ss_in_n;
        d.sclk = sclk_in;
        d.err  = q.ss_n && !ss_in_n && !q.sclk && sclk_in;
        early  = q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{ss_n: 1'b1, sclk: 1'b0, err: 1'b0};
        else        q <= d;
    end

endmodule

// File: rtl/spi_ss_seq.sv
module spi_ss_seq
    import spi_ss_seq_pkg::*;
#(
    parameter int MAX_BITS  = 32,
    parameter int DIV_SEL_W = 3,
    parameter int WAIT_W    = 8,
    localparam int LEN_W    = $clog2(MAX_BITS),
    localparam int PER_W    = WAIT_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic [MAX_BITS-1:0]  req_data,
    input  logic [LEN_W-1:0]     req_len_m1,
    input  logic [DIV_SEL_W-1:0] div_sel,
    input  logic [WAIT_W-1:0]    wait_cnt,
    input  logic                 spi_rdy,
    output logic                 req_ready,
    output logic                 ss_n,
    output logic                 sclk,
    output logic                 mosi,
    input  logic                 miso,
    output logic [MAX_BITS-1:0]  rx_data,
    output logic                 done,
    input  logic                 slv_ss_n,
    input  logic                 slv_sclk,
    output logic                 slv_early
);

    typedef struct packed {
        seq_state_e           state;
        logic                 dly;
        logic [LEN_W:0]       bits_left;
        logic [DIV_SEL_W-1:0] div;
        logic [WAIT_W-1:0]    wait_n;
        logic                 ss_n;
        logic                 sclk;
        logic                 done;
    } seq_t;

    seq_t             d, q;
    logic             tmr_clr, tmr_run, tmr_mid, tmr_last;
    logic [PER_W-1:0] tmr_per;
    logic             sh_load, sh_out, sh_in;

    spi_ss_seq_timer #(.DIV_SEL_W(DIV_SEL_W), .PER_W(PER_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tmr_run),
        .clr     (tmr_clr),
        .div_sel (q.div),
        .mid     (tmr_mid),
        .last    (tmr_last),
        .per     (tmr_per)
    );

    spi_ss_seq_shift #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (sh_load),
        .data      (req_data),
        .len_m1    (req_len_m1),
        .shift_out (sh_out),
        .sample_in (sh_in),
        .miso      (miso),
        .mosi      (mosi),
        .rx_data   (rx_data)
    );

    spi_ss_seq_slvchk u_slvchk (
        .clk     (clk),
        .rst_n   (rst_n),
        .ss_in_n (slv_ss_n),
        .sclk_in (slv_sclk),
        .early   (slv_early)
    );

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        tmr_clr   = 1'b0;
        sh_load   = 1'b0;
        sh_out    = 1'b0;
        sh_in     = 1'b0;
        req_ready = (q.state == ST_IDLE) && spi_rdy;
        tmr_run   = (q.state != ST_IDLE) && (q.state != ST_DLY);
        unique case (q.state)
            ST_IDLE: begin
                if (req_valid && spi_rdy) begin
                    sh_load     = 1'b1;
                    d.div       = div_sel;
                    d.wait_n    = wait_cnt;
                    d.bits_left = (LEN_W+1)'(req_len_m1) + (LEN_W+1)'(1);
                    d.dly       = 1'b0;
                    d.state     = ST_DLY;
                end
            end
            ST_DLY: begin
                if (q.dly) begin
                    d.ss_n  = 1'b0;
                    d.state = ST_LEAD;
                    tmr_clr = 1'b1;
                end else begin
                    d.dly = 1'b1;
                end
            end
            ST_LEAD: begin
                if (tmr_last && tmr_per == PER_W'(2)) begin
                    d.state = ST_SHIFT;
                    tmr_clr = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tmr_mid) begin
                    d.sclk = 1'b1;
                    sh_in  = 1'b1;
                end
                if (tmr_last) begin
                    d.sclk      = 1'b0;
                    sh_out      = 1'b1;
                    d.bits_left = q.bits_left - (LEN_W+1)'(1);
                    if (q.bits_left == (LEN_W+1)'(1)) begin
                        d.state = ST_LAG;
                        tmr_clr = 1'b1;
                    end
                end
            end
            ST_LAG: begin
                if (tmr_last && tmr_per == PER_W'(1)) begin
                    d.ss_n  = 1'b1;
                    d.done  = 1'b1;
                    d.state = ST_GAP;
                    tmr_clr = 1'b1;
                end
            end
            ST_GAP: begin
                if (tmr_last && tmr_per == PER_W'(q.wait_n)) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        ss_n = q.ss_n;
        sclk = q.sclk;
        done = q.done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.ss_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/spi_ss_seq_chk.sv
module spi_ss_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic spi_rdy,
    input logic req_ready,
    input logic ss_n,
    input logic sclk,
    input logic mosi,
    input logic done
);

    a_r1_ready_gates_accept: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> spi_rdy);

    a_r2_select_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ss_n) |-> $past(spi_rdy, 3));

    a_r6_clock_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n |-> !sclk);

    a_r7_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk && $past(sclk)) |-> $stable(mosi));

    a_r9_done_with_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_n) |-> done);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind spi_ss_seq spi_ss_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_rdy   (spi_rdy),
    .req_ready (req_ready),
    .ss_n      (ss_n),
    .sclk      (sclk),
    .mosi      (mosi),
    .done      (done)
);

// File: tb/tb_spi_ss_seq.sv
`timescale 1ns/1ps
module tb_spi_ss_seq;

    typedef struct {
        logic [31:0] data;
        int          len;
        int          per;
        int          wt;
        logic [31:0] sw;
        int          acc;
        bit          b2b;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_data = '0;
    logic [4:0]  req_len_m1 = '0;
    logic [2:0]  div_sel = '0;
    logic [7:0]  wait_cnt = '0;
    logic        spi_rdy = 1'b0;
    logic        req_ready, ss_n, sclk, mosi, done, slv_early;
    logic        miso = 1'b0;
    logic [31:0] rx_data;
    logic        slv_ss_n = 1'b1;
    logic        slv_sclk = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int frames = 0;
    int idle_bad = 0;
    item_t sbq[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spi_ss_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_data(req_data),
        .req_len_m1(req_len_m1), .div_sel(div_sel), .wait_cnt(wait_cnt),
        .spi_rdy(spi_rdy), .req_ready(req_ready), .ss_n(ss_n), .sclk(sclk),
        .mosi(mosi), .miso(miso), .rx_data(rx_data), .done(done),
        .slv_ss_n(slv_ss_n), .slv_sclk(slv_sclk), .slv_early(slv_early)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mask_of(input int len);
        logic [63:0] m;
        m = (64'd1 << len) - 64'd1;
        return m[31:0];
    endfunction

    // Driver: waits for acceptance, then pushes the expected frame.
    task automatic drive(input logic [31:0] data, input int len, input int sel,
                         input int wt, input logic [31:0] sw, input bit b2b);
        item_t it;
        req_valid  = 1'b1;
        req_data   = data;
        req_len_m1 = 5'(len - 1);
        div_sel    = 3'(sel);
        wait_cnt   = 8'(wt);
        forever begin
            #1;
            if (req_ready) break;
            @(negedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        it.data = data; it.len = len; it.per = 4 << sel; it.wt = wt;
        it.sw = sw; it.acc = cyc; it.b2b = b2b;
        sbq.push_back(it);
    endtask

    // Monitor and slave model.
    item_t cur;
    logic  ss_p = 1'b1, sclk_p = 1'b0;
    int    t_fall, t_first, t_lastfall, t_rise, idx, nb, pp, pw;
    logic [31:0] txc;
    bit    chk_next = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (ss_n && sclk) idle_bad++;
            if (!ss_n && ss_p) begin
                if (sbq.size() > 0) cur = sbq[0];
                t_fall = cyc;
                check(t_fall - cur.acc == 2, "R2 select fall delay", t_fall - cur.acc, 2);
                if (cur.b2b)
                    check(t_fall - t_rise == (1 + pw) * pp + 3, "R5 inter-frame gap",
                          t_fall - t_rise, (1 + pw) * pp + 3);
                idx = cur.len - 1;
                miso = cur.sw[idx];
                nb = 0; txc = '0;
            end
            if (sclk && !sclk_p) begin
                nb++;
                txc = {txc[30:0], mosi};
                if (nb == 1) begin
                    t_first = cyc;
                    check(t_first - t_fall == 3 * cur.per + cur.per / 2, "R3 lead time",
                          t_first - t_fall, 3 * cur.per + cur.per / 2);
                end
                if (nb == 2)
                    check(cyc - t_first == cur.per, "R6 sclk period", cyc - t_first, cur.per);
            end
            if (!sclk && sclk_p) begin
                t_lastfall = cyc;
                idx--;
                if (idx >= 0) miso = cur.sw[idx];
            end
            if (chk_next) begin
                check(done == 1'b0, "R9 done one cycle", done, 0);
                chk_next = 0;
            end
            if (ss_n && !ss_p) begin
                void'(sbq.pop_front());
                t_rise = cyc;
                check(t_rise - t_lastfall == 2 * cur.per, "R4 lag time",
                      t_rise - t_lastfall, 2 * cur.per);
                check(nb == cur.len, "R7 bit count", nb, cur.len);
                check(txc == (cur.data & mask_of(cur.len)), "R7 mosi data",
                      txc, cur.data & mask_of(cur.len));
                check(rx_data == (cur.sw & mask_of(cur.len)), "R8 rx data",
                      rx_data, cur.sw & mask_of(cur.len));
                check(done == 1'b1, "R9 done with select rise", done, 1);
                chk_next = 1;
                pp = cur.per; pw = cur.wt;
                frames++;
            end
            ss_p = ss_n; sclk_p = sclk;
        end
    end

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                check(0, "watchdog", cyc, 0);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(ss_n == 1'b1, "R11 ss_n reset", ss_n, 1);
        check(sclk == 1'b0, "R11 sclk reset", sclk, 0);
        check(done == 1'b0, "R11 done reset", done, 0);
        check(slv_early == 1'b0, "R11 slv_early reset", slv_early, 0);
        check(rx_data == 32'd0, "R11 rx_data reset", rx_data, 0);

        // R1: ready low holds the request off
        fork
            begin
                bit held;
                held = 1;
                repeat (300) begin
                    @(negedge clk);
                    if (!ss_n || sclk || req_ready) held = 0;
                end
                check(held, "R1 wait while ready low", {ss_n, sclk, req_ready}, 3'b100);
                spi_rdy = 1'b1;
            end
            drive(32'h0000_00A5, 8, 0, 0, 32'hFFFF_FF3C, 0);
        join
        drive(32'hDEAD_BEEF, 32, 1, 3, 32'h1234_5678, 1);
        drive(32'h0000_0001, 1, 2, 2, 32'hFFFF_FFFF, 1);
        drive(32'hFFFF_1ABC, 13, 0, 5, 32'hABCD_0F0F, 1);
        drive(32'h0000_0002, 2, 7, 0, 32'h0000_0001, 1);
        while (frames < 5) @(negedge clk);
        @(negedge clk);
        spi_rdy = 1'b0;
        check(idle_bad == 0, "R6 sclk low while deselected", idle_bad, 0);

        // R10 slave-mode check: one clock apart, no flag
        @(negedge clk); slv_ss_n = 1'b0;
        @(negedge clk); slv_sclk = 1'b1;
        @(negedge clk);
        check(slv_early == 1'b0, "R10 legal slave edge", slv_early, 0);
        slv_sclk = 1'b0; slv_ss_n = 1'b1;
        repeat (2) @(negedge clk);
        // same sample: flag
        slv_ss_n = 1'b0; slv_sclk = 1'b1;
        @(negedge clk);
        check(slv_early == 1'b1, "R10 early slave edge", slv_early, 1);
        @(negedge clk);
        check(slv_early == 1'b0, "R10 flag is a pulse", slv_early, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule